// File: doc/BRIEF.md
# Comparator Timer with Write Acknowledge

This block is a 64-bit global timer on a plain 32-bit register port. A free-running counter advances on a tick-enable input. A single 64-bit comparator raises an event when the counter reaches it. In auto-increment mode the comparator then moves forward by a programmed step, so the event repeats at a fixed period and software does not have to rewrite it.

Writes to the counter halves, the comparator halves, the step register and the control register do not land at once. Each one passes through a fixed acceptance delay that stands in for a crossing into the timer domain. When the value lands, a per-register flag rises in one of two write-status registers. Software polls that flag and acknowledges it by writing a 1 to it. The interrupt-enable and interrupt-status registers are written immediately.

Top module: `gtimer_wack`

## Requirements
- R1: A write to a delayed register (0x00, 0x04, 0x10, 0x14, 0x18, 0x1C) becomes visible exactly ACC_DELAY (default 4) clock edges after the edge that samples the write. Its write-status flag rises at that same edge and not earlier.
- R2: The counter reads as its low word at 0x00 and its high word at 0x04. A write to either word replaces only those 32 bits.
- R3: Counter write-status at 0x08 has bit 0 for the low word and bit 1 for the high word. Writing 1 to a bit clears only that bit.
- R4: General write-status at 0x28 has bit 0 for comparator low (0x10), bit 1 for comparator high (0x14), bit 2 for the step (0x18) and bit 3 for control (0x1C). Writes to any other address set no write-status bit, and the bits are cleared by writing 1.
- R5: While control bit 0 (start) is set, the counter increments by one on each clock edge that samples tick_en high. Otherwise it holds. A landing counter write takes precedence over the increment.
- R6: When control bit 1 (compare enable) is set and the counter equals the comparator, interrupt status 0x20 bit 0 is set and stays set. irq pulses only if interrupt enable 0x24 bit 0 is set.
- R7: Each match gives one irq pulse, one cycle wide, one edge after equality appears. An equality that persists while neither the counter nor the comparator changes gives no further pulse.
- R8: With control bit 2 (auto-increment) set, each match adds the step at 0x18 to the comparator. With tick_en held high, pulses then recur every step cycles.
- R9: Writing a 1 in bit 0 to 0x20 clears interrupt status at the next edge. Writes to 0x24 take effect at the next edge.
- R10: After reset every register reads 0 and irq is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter advance qualifier |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench builds the block with its defaults: 32-bit words, a 6-bit address and an acceptance delay of 4. With a delay this short, it can sample each cycle of the landing window and find the exact edge where value and flag appear. Because the counter starts at zero and the step is small, random comparator positions and step sizes down to 1 reach several periodic matches within a few dozen cycles. A step of 1 gives back-to-back pulses. A stopped counter that sits on the comparator tests the single-pulse rule.

// File: rtl/gtimer_wack.sv
module gtimer_wack #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int ACC_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CWST   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_ISTAT  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_GWST   = ADDR_W'(8'h28);

  logic [CNT_W-1:0]  cnt, cmp;
  logic [DATA_W-1:0] incr;
  logic              start, cmp_en, autoinc, int_en, int_stat, seen_q;
  logic [1:0]        cwstat;
  logic [3:0]        gwstat;

  logic              in_sync;
  logic [2:0]        in_code;
  logic              pv [ACC_DELAY];
  logic [2:0]        pc [ACC_DELAY];
  logic [DATA_W-1:0] pd [ACC_DELAY];

  always_comb begin
    in_sync = bus_wr;
    in_code = 3'd0;
    unique case (bus_addr)
      A_CNT_LO: in_code = 3'd0;
      A_CNT_HI: in_code = 3'd1;
      A_CMP_LO: in_code = 3'd2;
      A_CMP_HI: in_code = 3'd3;
      A_STEP:   in_code = 3'd4;
      A_CTRL:   in_code = 3'd5;
      default:  in_sync = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ACC_DELAY; i++) begin
        pv[i] <= 1'b0;
        pc[i] <= '0;
        pd[i] <= '0;
      end
    end else begin
      pv[0] <= in_sync;
      pc[0] <= in_code;
      pd[0] <= bus_wdata;
      for (int i = 1; i < ACC_DELAY; i++) begin
        pv[i] <= pv[i-1];
        pc[i] <= pc[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  wire              app_v = pv[ACC_DELAY-1];
  wire [2:0]        app_c = pc[ACC_DELAY-1];
  wire [DATA_W-1:0] app_d = pd[ACC_DELAY-1];

  wire cnt_wr_lo = app_v && app_c == 3'd0;
  wire cnt_wr_hi = app_v && app_c == 3'd1;
  wire cmp_wr_lo = app_v && app_c == 3'd2;
  wire cmp_wr_hi = app_v && app_c == 3'd3;
  wire step_wr   = app_v && app_c == 3'd4;
  wire ctrl_wr   = app_v && app_c == 3'd5;

  wire match_now = cmp_en && (cnt == cmp);
  wire evt       = match_now && !seen_q;
  wire advance   = start && tick_en;
  wire cnt_upd   = cnt_wr_lo || cnt_wr_hi || advance;
  wire cmp_step  = evt && autoinc && (incr != '0);
  wire cmp_upd   = cmp_wr_lo || cmp_wr_hi || cmp_step;

  wire wr_cwst  = bus_wr && bus_addr == A_CWST;
  wire wr_gwst  = bus_wr && bus_addr == A_GWST;
  wire wr_istat = bus_wr && bus_addr == A_ISTAT;
  wire wr_ien   = bus_wr && bus_addr == A_IEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_wr_lo) cnt[DATA_W-1:0] <= app_d;
    else if (cnt_wr_hi) cnt[CNT_W-1:DATA_W] <= app_d;
    else if (advance) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else if (cmp_wr_lo) cmp[DATA_W-1:0] <= app_d;
    else if (cmp_wr_hi) cmp[CNT_W-1:DATA_W] <= app_d;
    else if (cmp_step) cmp <= cmp + {{DATA_W{1'b0}}, incr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incr    <= '0;
      start   <= 1'b0;
      cmp_en  <= 1'b0;
      autoinc <= 1'b0;
    end else begin
      if (step_wr) incr <= app_d;
      if (ctrl_wr) {autoinc, cmp_en, start} <= app_d[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      int_stat <= 1'b0;
      int_en   <= 1'b0;
      irq      <= 1'b0;
      cwstat   <= '0;
      gwstat   <= '0;
    end else begin
      seen_q <= match_now && !cnt_upd && !cmp_upd;
      irq    <= evt && int_en;
      if (evt) int_stat <= 1'b1;
      else if (wr_istat && bus_wdata[0]) int_stat <= 1'b0;
      if (wr_ien) int_en <= bus_wdata[0];
      cwstat <= (cwstat & ~(wr_cwst ? bus_wdata[1:0] : 2'b00))
              | {cnt_wr_hi, cnt_wr_lo};
      gwstat <= (gwstat & ~(wr_gwst ? bus_wdata[3:0] : 4'b0000))
              | {ctrl_wr, step_wr, cmp_wr_hi, cmp_wr_lo};
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      A_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
      A_CWST:   bus_rdata = DATA_W'(cwstat);
      A_CMP_LO: bus_rdata = cmp[DATA_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CNT_W-1:DATA_W];
      A_STEP:   bus_rdata = incr;
      A_CTRL:   bus_rdata = DATA_W'({autoinc, cmp_en, start});
      A_ISTAT:  bus_rdata = DATA_W'(int_stat);
      A_IEN:    bus_rdata = DATA_W'(int_en);
      A_GWST:   bus_rdata = DATA_W'(gwstat);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gtimer_wack_chk.sv
module gtimer_wack_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                irq,
  input logic                start,
  input logic                autoinc,
  input logic                int_en,
  input logic                int_stat,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*DATA_W-1:0] cmp,
  input logic [DATA_W-1:0]   incr,
  input logic                cnt_wr_lo,
  input logic                cnt_wr_hi,
  input logic                cmp_wr_lo,
  input logic                cmp_wr_hi,
  input logic                evt,
  input logic [1:0]          cwstat
);
  p_irq_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_stat);
  p_irq_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_en));
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tick_en && !cnt_wr_lo && !cnt_wr_hi) |=> cnt == $past(cnt) + 1'b1);
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(start && tick_en) && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt));
  p_autoinc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && autoinc && !cmp_wr_lo && !cmp_wr_hi) |=>
      cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(incr)});
  p_wstat_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cwstat[0]) |-> $past(cnt_wr_lo));
endmodule

bind gtimer_wack gtimer_wack_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq(irq), .start(start),
  .autoinc(autoinc), .int_en(int_en), .int_stat(int_stat), .cnt(cnt),
  .cmp(cmp), .incr(incr), .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi),
  .cmp_wr_lo(cmp_wr_lo), .cmp_wr_hi(cmp_wr_hi), .evt(evt), .cwstat(cwstat)
);

// File: tb/test_gtimer_wack.sv
module test_gtimer_wack;
  localparam int CLK_P = 10;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic          irq;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  gtimer_wack i_gtimer_wack (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] exp_cmp(logic [DW-1:0] c, logic [DW-1:0] n, int k);
    return c + n * DW'(k);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int limit;
    limit = 0;
    while (!done && limit < 200000) begin @(posedge clk); limit++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4711));
    idle(2); rst_n = 1'b1; @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 12; a++) begin
      rd(AW'(a * 4), v); chk("R10 reset read", v, 0);
    end
    rd(AW'(8'h30), v); chk("R10 unmapped", v, 0);
    chk("R10 irq reset", DW'(irq), 0);

    // R1 landing window for counter low
    wr(AW'(8'h00), 32'h1234_5678);
    for (int k = 1; k <= 3; k++) begin
      idle(1); rd(AW'(8'h00), v); chk("R1 early value", v, 0);
      rd(AW'(8'h08), v); chk("R1 early flag", v, 0);
    end
    idle(1); rd(AW'(8'h00), v); chk("R1 landed value", v, 32'h1234_5678);
    rd(AW'(8'h08), v); chk("R1 landed flag", v, 1);

    // R2 high word write keeps low word
    wr(AW'(8'h04), 32'hCAFE_0001); idle(4);
    rd(AW'(8'h04), v); chk("R2 high word", v, 32'hCAFE_0001);
    rd(AW'(8'h00), v); chk("R2 low kept", v, 32'h1234_5678);

    // R3 W1C per bit
    rd(AW'(8'h08), v); chk("R3 both flags", v, 3);
    wr(AW'(8'h08), 1); rd(AW'(8'h08), v); chk("R3 clear bit0", v, 2);
    wr(AW'(8'h08), 2); rd(AW'(8'h08), v); chk("R3 clear bit1", v, 0);

    // R4 general flags
    wr(AW'(8'h10), 1); wr(AW'(8'h14), 0); wr(AW'(8'h18), 5); wr(AW'(8'h1C), 0);
    idle(5); rd(AW'(8'h28), v); chk("R4 four flags", v, 4'hF);
    wr(AW'(8'h28), 4'h5); rd(AW'(8'h28), v); chk("R4 partial clear", v, 4'hA);
    wr(AW'(8'h28), 4'hA);
    wr(AW'(8'h24), 0); wr(AW'(8'h30), 32'hFFFF); wr(AW'(8'h20), 1); idle(6);
    rd(AW'(8'h28), v); chk("R4 no flag from others", v, 0);
    rd(AW'(8'h08), v); chk("R4 no counter flag", v, 0);

    // R5 counting with random tick pattern
    wr(AW'(8'h00), 0); wr(AW'(8'h04), 0); wr(AW'(8'h1C), 1); idle(6);
    rd(AW'(8'h00), v); chk("R5 no tick no count", v, 0);
    begin
      int ones; ones = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk); tick_en = 1'($urandom_range(0, 1));
        ones += int'(tick_en);
      end
      @(negedge clk); tick_en = 1'b0;
      rd(AW'(8'h00), v); chk("R5 tick count", v, DW'(ones));
    end
    wr(AW'(8'h1C), 0); idle(5); tick_en = 1'b1; idle(5); tick_en = 1'b0;
    rd(AW'(8'h00), v); rd(AW'(8'h00), v);
    begin
      logic [DW-1:0] hold; hold = v; idle(3);
      rd(AW'(8'h00), v); chk("R5 stopped holds", v, hold);
    end

    // R6 match with interrupt disabled, R9 clear
    wr(AW'(8'h00), 0); wr(AW'(8'h10), 10); wr(AW'(8'h14), 0); wr(AW'(8'h1C), 3);
    idle(5); tick_en = 1'b1;
    begin
      int pulses; pulses = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); pulses += int'(irq); end
      chk("R6 masked irq", DW'(pulses), 0);
    end
    rd(AW'(8'h20), v); chk("R6 sticky status", v, 1);
    wr(AW'(8'h20), 1); rd(AW'(8'h20), v); chk("R9 status cleared", v, 0);

    // R7 stationary equality gives one pulse
    tick_en = 1'b0; wr(AW'(8'h24), 1); rd(AW'(8'h24), v); chk("R9 enable set", v, 1);
    rd(AW'(8'h00), v); wr(AW'(8'h10), v);
    begin
      int pulses; pulses = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); pulses += int'(irq); end
      chk("R7 single pulse", DW'(pulses), 1);
    end
    rd(AW'(8'h20), v); chk("R6 status on match", v, 1);

    // R8 auto-increment, random comparator and step
    for (int t = 0; t < 6; t++) begin
      logic [DW-1:0] c, n;
      int last, now, cyc, k;
      c = DW'($urandom_range(5, 30));
      n = (t == 0) ? 1 : DW'($urandom_range(1, 20));
      tick_en = 1'b0;
      wr(AW'(8'h1C), 0); wr(AW'(8'h00), 0); wr(AW'(8'h04), 0); wr(AW'(8'h18), n);
      wr(AW'(8'h10), c); wr(AW'(8'h14), 0); wr(AW'(8'h1C), 7);
      idle(5); wr(AW'(8'h20), 1); wr(AW'(8'h24), 1);
      @(negedge clk); tick_en = 1'b1;
      k = 0; cyc = 0; last = -1;
      while (k < 3 && cyc < 400) begin
        @(negedge clk); cyc++;
        if (irq) begin
          k++; now = cyc;
          rd(AW'(8'h10), v); chk("R8 comparator advance", v, exp_cmp(c, n, k));
          if (last >= 0) chk("R8 period", DW'(now - last), n);
          last = now;
        end
      end
      chk("R8 pulse count", DW'(k), 3);
    end
    tick_en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule